// File: doc/BRIEF.md
# 1-Wire bus master slot engine

This block is the timing core of a 1-Wire bus master. A client issues one command at a time: a bus reset with presence detection, a single write slot, a single read slot, or a full byte exchange. The engine produces the open-drain drive pattern from a 1 µs timebase divided down from the system clock. It samples the returned bus level through a synchronizer and a glitch filter, and reports the presence flag, the sampled bit or byte and two error flags through a busy/done handshake.

The engine decodes every slot by measuring how long the filtered bus stays low. It does not sample at a fixed point. A short low (only the master's own opening pulse) reads as 1, and a long low reads as 0. Presence is accepted only when the first low pulse after the reset low is released has a length inside a narrow window. The bus is modelled as a drive-low enable plus a sampled input, and an external pull-up is assumed. The client handles ROM commands, enumeration and CRC checks.

Top module: `owm_slot_engine`

## Requirements
- R1: Every phase length counts ticks of a 1 µs timebase, made by dividing the system clock by CLK_PER_US. Each drive-low phase lasts exactly its tick count times CLK_PER_US clocks.
- R2: A reset command leaves the bus released for 60 µs, drives it low for 600 µs, and then releases it for a 600 µs observation window before finishing.
- R3: After a reset, presence is 1 only if a low pulse starts after the reset low has been seen released, ends inside the window, and has a measured length strictly above 100 µs and strictly below 200 µs. In every other case presence is 0. Non-reset commands return presence 0.
- R4: A slot that sends 0 drives the bus low for 70 µs and then releases it for 3 µs. A slot that sends 1, and every read slot, drives low for 3 µs and then releases for 70 µs.
- R5: A slot returns 1 when the filtered bus-low time measured over the slot and its recovery (the master's own pulse included) is below 20 µs. Otherwise it returns 0.
- R6: An exchange-byte command runs eight slots, sending wdata bit 0 first. The bit sampled in slot k is placed at rdata bit k.
- R7: If the filtered bus is low when a command is presented while idle, the command is refused. The bus is never driven, and done rises on the next clock with err_idle=1.
- R8: Bus pulses, low or high, shorter than FILT_CYC (10) system clocks do not change the filtered level.
- R9: A command still active TIMEOUT_US (10000) µs after acceptance is aborted. The bus is released and done rises with err_timeout=1, after which the engine accepts new commands.
- R10: start is accepted only while busy=0 and is ignored while busy=1. done is high for one clock with valid rdata, presence and error flags. A start raised in the done cycle is accepted.
- R11: The op encoding is 0 reset, 1 write bit (value in wdata[0]), 2 read bit, 3 exchange byte. A single-slot command returns its bit in rdata[0], with rdata[7:1]=0.
- R12: After reset, bus_drive_low, busy and done are 0, and the bus is driven low only while busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request pulse |
| op | input | 2 | Command code (0 reset, 1 write bit, 2 read bit, 3 exchange byte) |
| wdata | input | 8 | Bit or byte to send |
| bus_in | input | 1 | Sampled bus level |
| bus_drive_low | output | 1 | 1 pulls the bus low, 0 releases it |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion strobe |
| rdata | output | 8 | Sampled bit (bit 0) or byte |
| presence | output | 1 | Presence detected on the last reset |
| err_idle | output | 1 | Command refused because the bus was low |
| err_timeout | output | 1 | Command aborted by the timeout |

## Verification
Two functions can fall in the same clock: the completion of one command (done high, engine back in idle) and the acceptance of the next start. The bench provokes this by raising start in the very cycle it sees done. It then expects busy on the following clock, drive pulses of the new command with the exact width the reference model predicts, and the correct byte from the finished command. A second overlap is a refused command whose done coincides with a fresh start while the bus is still low. It is covered by the checker's one-clock done rule, which allows a new done only when a start was present.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRBIT = 2'd1,
    OP_RDBIT = 2'd2,
    OP_XBYTE = 2'd3
  } owm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LEAD,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_SLOT_LOW,
    ST_SLOT_REL,
    ST_RECOVER
  } owm_state_e;
endpackage

// File: rtl/owm_tick_gen.sv
`timescale 1ns/1ps
module owm_tick_gen #(
  parameter int DIV = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || clr) cnt <= '0;
    else if (tick)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/owm_glitch_filter.sv
`timescale 1ns/1ps
module owm_glitch_filter #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      level <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == level) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/owm_slot_engine.sv
`timescale 1ns/1ps
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int CLK_PER_US    = 80,
  parameter int RST_LEAD_US   = 60,
  parameter int RST_LOW_US    = 600,
  parameter int RST_WAIT_US   = 600,
  parameter int PRES_MIN_US   = 100,
  parameter int PRES_MAX_US   = 200,
  parameter int SLOT_LONG_US  = 70,
  parameter int SLOT_SHORT_US = 3,
  parameter int READ_THR_US   = 20,
  parameter int FILT_CYC      = 10,
  parameter int TIMEOUT_US    = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [7:0] wdata,
  input  logic       bus_in,
  output logic       bus_drive_low,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       presence,
  output logic       err_idle,
  output logic       err_timeout
);
  localparam int M1     = (RST_LOW_US > RST_WAIT_US) ? RST_LOW_US : RST_WAIT_US;
  localparam int M2     = (M1 > RST_LEAD_US) ? M1 : RST_LEAD_US;
  localparam int PH_MAX = (M2 > SLOT_LONG_US) ? M2 : SLOT_LONG_US;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TMO_W  = $clog2(TIMEOUT_US + 1);
  localparam int LC_W   = $clog2(READ_THR_US + 1) + 1;
  localparam int PL_W   = $clog2(PRES_MAX_US + 1) + 1;
  localparam logic [LC_W-1:0] LC_SAT = '1;
  localparam logic [PL_W-1:0] PL_SAT = '1;

  owm_state_e      state;
  owm_op_e         op_q;
  logic            tick, restart, filt;
  logic [PH_W-1:0] ph_cnt, phase_len;
  logic [TMO_W-1:0] tmo_cnt;
  logic [2:0]      bit_idx;
  logic [7:0]      tx_q, sh;
  logic [LC_W-1:0] low_cnt;
  logic [PL_W-1:0] pres_len;
  logic            seen_high, in_pulse, pres_done;
  logic            cur_bit, phase_end, tmo_hit, slot_bit, more_bits, pres_ok, in_slot;

  owm_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .en(state != ST_IDLE), .clr(restart), .tick(tick)
  );

  owm_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .raw(bus_in), .level(filt)
  );

  always_comb begin
    cur_bit = tx_q[bit_idx];
    case (state)
      ST_RST_LEAD: phase_len = PH_W'(RST_LEAD_US);
      ST_RST_LOW:  phase_len = PH_W'(RST_LOW_US);
      ST_RST_WAIT: phase_len = PH_W'(RST_WAIT_US);
      ST_SLOT_LOW: phase_len = cur_bit ? PH_W'(SLOT_SHORT_US) : PH_W'(SLOT_LONG_US);
      ST_SLOT_REL: phase_len = cur_bit ? PH_W'(SLOT_LONG_US) : PH_W'(SLOT_SHORT_US);
      default:     phase_len = PH_W'(PH_MAX);
    endcase
    phase_end = tick && (ph_cnt == phase_len - PH_W'(1));
    tmo_hit   = tick && (tmo_cnt == TMO_W'(TIMEOUT_US - 1));
    slot_bit  = (low_cnt < LC_W'(READ_THR_US));
    more_bits = (op_q == OP_XBYTE) && (bit_idx != 3'd7);
    restart   = (state == ST_RECOVER) && filt && more_bits && !tmo_hit;
    pres_ok   = pres_done && (pres_len > PL_W'(PRES_MIN_US)) && (pres_len < PL_W'(PRES_MAX_US));
    in_slot   = (state == ST_SLOT_LOW) || (state == ST_SLOT_REL) || (state == ST_RECOVER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      op_q          <= OP_RESET;
      ph_cnt        <= '0;
      tmo_cnt       <= '0;
      bit_idx       <= '0;
      tx_q          <= '0;
      sh            <= '0;
      low_cnt       <= '0;
      pres_len      <= '0;
      seen_high     <= 1'b0;
      in_pulse      <= 1'b0;
      pres_done     <= 1'b0;
      bus_drive_low <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      rdata         <= '0;
      presence      <= 1'b0;
      err_idle      <= 1'b0;
      err_timeout   <= 1'b0;
    end else begin
      done <= 1'b0;

      if (tick) tmo_cnt <= tmo_cnt + 1'b1;
      if (phase_end)  ph_cnt <= '0;
      else if (tick)  ph_cnt <= ph_cnt + 1'b1;
      if (in_slot && tick && !filt && low_cnt != LC_SAT) low_cnt <= low_cnt + 1'b1;

      if (state == ST_RST_WAIT) begin
        if (filt && !in_pulse) seen_high <= 1'b1;
        if (seen_high && !filt && !pres_done) in_pulse <= 1'b1;
        if (in_pulse && filt) pres_done <= 1'b1;
        if (tick && in_pulse && !pres_done && !filt && pres_len != PL_SAT)
          pres_len <= pres_len + 1'b1;
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            if (!filt) begin
              done        <= 1'b1;
              err_idle    <= 1'b1;
              err_timeout <= 1'b0;
              presence    <= 1'b0;
              rdata       <= '0;
            end else begin
              busy      <= 1'b1;
              op_q      <= owm_op_e'(op);
              bit_idx   <= '0;
              ph_cnt    <= '0;
              tmo_cnt   <= '0;
              low_cnt   <= '0;
              sh        <= '0;
              pres_len  <= '0;
              seen_high <= 1'b0;
              in_pulse  <= 1'b0;
              pres_done <= 1'b0;
              case (owm_op_e'(op))
                OP_WRBIT: tx_q <= {7'd0, wdata[0]};
                OP_RDBIT: tx_q <= 8'h01;
                OP_XBYTE: tx_q <= wdata;
                default:  tx_q <= 8'h00;
              endcase
              if (owm_op_e'(op) == OP_RESET) begin
                state         <= ST_RST_LEAD;
                bus_drive_low <= 1'b0;
              end else begin
                state         <= ST_SLOT_LOW;
                bus_drive_low <= 1'b1;
              end
            end
          end
        end
        ST_RST_LEAD: if (phase_end) begin state <= ST_RST_LOW;  bus_drive_low <= 1'b1; end
        ST_RST_LOW:  if (phase_end) begin state <= ST_RST_WAIT; bus_drive_low <= 1'b0; end
        ST_RST_WAIT: if (phase_end) state <= ST_RECOVER;
        ST_SLOT_LOW: if (phase_end) begin state <= ST_SLOT_REL; bus_drive_low <= 1'b0; end
        ST_SLOT_REL: if (phase_end) state <= ST_RECOVER;
        ST_RECOVER: begin
          if (filt) begin
            if (more_bits) begin
              sh            <= {slot_bit, sh[7:1]};
              bit_idx       <= bit_idx + 1'b1;
              low_cnt       <= '0;
              ph_cnt        <= '0;
              state         <= ST_SLOT_LOW;
              bus_drive_low <= 1'b1;
            end else begin
              state       <= ST_IDLE;
              busy        <= 1'b0;
              done        <= 1'b1;
              err_idle    <= 1'b0;
              err_timeout <= 1'b0;
              case (op_q)
                OP_RESET: begin presence <= pres_ok; rdata <= '0; end
                OP_XBYTE: begin presence <= 1'b0; rdata <= {slot_bit, sh[7:1]}; end
                default:  begin presence <= 1'b0; rdata <= {7'd0, slot_bit}; end
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (state != ST_IDLE && tmo_hit) begin
        state         <= ST_IDLE;
        busy          <= 1'b0;
        done          <= 1'b1;
        bus_drive_low <= 1'b0;
        err_idle      <= 1'b0;
        err_timeout   <= 1'b1;
        presence      <= 1'b0;
        rdata         <= '0;
      end
    end
  end
endmodule

// File: rtl/owm_slot_engine_chk.sv
`timescale 1ns/1ps
module owm_slot_engine_chk #(
  parameter int CLK_PER_US = 80,
  parameter int RST_LOW_US = 600
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic bus_drive_low,
  input logic err_idle,
  input logic err_timeout,
  input logic presence,
  input logic filt_level
);
  localparam int unsigned MAX_LOW = RST_LOW_US * CLK_PER_US;

  int unsigned lo_run;

  always_ff @(posedge clk) begin
    if (rst || !bus_drive_low) lo_run <= 0;
    else                       lo_run <= lo_run + 1;
  end

  // R2: no drive-low stretch is longer than the reset low
  p_low_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bus_drive_low |-> lo_run < MAX_LOW);

  // R7: a start seen while the filtered bus is low is refused at once
  p_idle_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !filt_level |=> done && err_idle && !busy && !bus_drive_low);

  // R9: a timeout leaves the bus released and the engine idle
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (rst)
    done && err_timeout |-> !bus_drive_low && !busy && !err_idle && !presence);

  // R10: accepted start makes the engine busy
  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    start && !busy && filt_level |=> busy);

  // R10: busy only rises from a start
  p_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R10: busy only falls together with done
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy || done);

  // R10: done is a single-clock strobe unless a new start came in
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  // R12: the bus is pulled low only during a command
  p_drive_busy_r12: assert property (@(posedge clk) disable iff (rst)
    bus_drive_low |-> busy);
endmodule

bind owm_slot_engine owm_slot_engine_chk #(
  .CLK_PER_US(CLK_PER_US),
  .RST_LOW_US(RST_LOW_US)
) u_chk (
  .clk(clk),
  .rst(rst),
  .start(start),
  .busy(busy),
  .done(done),
  .bus_drive_low(bus_drive_low),
  .err_idle(err_idle),
  .err_timeout(err_timeout),
  .presence(presence),
  .filt_level(filt)
);

// File: tb/owm_slot_engine_test.sv
`timescale 1ns/1ps
module owm_slot_engine_test;
  localparam int CPU   = 4;
  localparam int US_NS = CPU * 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       drv, busy, done, presence, err_idle, err_timeout;
  logic [7:0] rdata;
  logic       dev_pres = 1'b0, dev_slot = 1'b0, dev_stuck = 1'b0, dev_hold = 1'b0;
  logic       bus_in;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int pres_us = 0;
  logic [7:0] pat = 8'hFF;
  int pidx = 0;
  int exp_q[$];
  int run = 0;

  always #2.5 clk = ~clk;

  assign bus_in = !(drv | dev_pres | dev_slot | dev_stuck | dev_hold);

  owm_slot_engine #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .wdata(wdata), .bus_in(bus_in),
    .bus_drive_low(drv), .busy(busy), .done(done), .rdata(rdata),
    .presence(presence), .err_idle(err_idle), .err_timeout(err_timeout)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference drive model: every completed low pulse must match the next expected width.
  always @(negedge clk) begin
    if (drv) begin
      run++;
      if (!busy) chk(1'b0, "R12 drive while idle", 1, 0);
    end else if (run > 0) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected drive pulse", run, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(run == e, "R1 R2 R4 drive-low width", run, e);
      end
      run = 0;
    end
  end

  // Device: presence pulse 30 us after the reset low ends
  initial forever begin
    @(negedge drv);
    if (mode == 1) begin
      #(30 * US_NS);
      dev_pres = 1'b1;
      #(pres_us * US_NS);
      dev_pres = 1'b0;
    end
  end

  // Device: slot responder (mode 2) or stuck-low bus (mode 3)
  initial forever begin
    @(posedge drv);
    if (mode == 2) begin
      logic b;
      b = pat[pidx % 8];
      pidx++;
      if (!b) begin
        dev_slot = 1'b1;
        #(40 * US_NS);
        dev_slot = 1'b0;
      end
    end else if (mode == 3) begin
      dev_stuck = 1'b1;
    end
  end

  task automatic kick(input logic [1:0] o, input logic [7:0] d);
    op = o;
    wdata = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, "R10 no done", 0, 1);
  endtask

  task automatic push_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i] ? 3 * CPU : 70 * CPU);
  endtask

  task automatic do_reset(input int m, input int plen, input logic exp_pres, input string tag);
    int cyc;
    mode = m;
    pres_us = plen;
    exp_q.push_back(600 * CPU);
    kick(2'd0, 8'h00);
    wait_done(cyc);
    chk(presence == exp_pres, tag, presence, exp_pres);
    chk(cyc >= 5036 && cyc <= 5050, "R2 reset duration", cyc, 5042);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one clock", done, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic do_slot(input logic [1:0] o, input logic wbit, input logic exp_bit, input string tag);
    int cyc;
    exp_q.push_back(wbit ? 3 * CPU : 70 * CPU);
    kick(o, {7'd0, wbit});
    wait_done(cyc);
    chk(rdata == {7'd0, exp_bit}, tag, rdata, exp_bit);
    chk(cyc >= 292 && cyc <= 310, "R4 slot duration", cyc, 294);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_byte(input logic [7:0] d, input logic [7:0] exp_b, input string tag);
    int cyc;
    push_byte(d);
    kick(2'd3, d);
    wait_done(cyc);
    chk(rdata == exp_b, tag, rdata, exp_b);
    chk(presence == 1'b0, "R3 no presence on byte", presence, 0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    chk(drv == 1'b0, "R12 reset drive", drv, 0);
    chk(busy == 1'b0, "R12 reset busy", busy, 0);
    chk(done == 1'b0, "R12 reset done", done, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    do_reset(0, 0,   1'b0, "R3 no device");
    do_reset(1, 150, 1'b1, "R3 presence 150us");
    do_reset(1, 60,  1'b0, "R3 presence too short");
    do_reset(1, 250, 1'b0, "R3 presence too long");
    mode = 0;

    do_slot(2'd1, 1'b0, 1'b0, "R4 R11 write 0");
    do_slot(2'd1, 1'b1, 1'b1, "R4 R11 write 1");
    do_slot(2'd2, 1'b1, 1'b1, "R5 read idle bus");
    mode = 2; pat = 8'h00; pidx = 0;
    do_slot(2'd2, 1'b1, 1'b0, "R5 read device 0");
    mode = 0;

    do_byte(8'hA5, 8'hA5, "R6 byte no device");
    mode = 2; pat = 8'h3C; pidx = 0;
    do_byte(8'hFF, 8'h3C, "R6 byte read 3C");
    pidx = 0;
    do_byte(8'h96, 8'h14, "R6 byte mixed");
    mode = 0;

    // R10: start while busy is ignored
    push_byte(8'h5A);
    kick(2'd3, 8'h5A);
    repeat (100) @(negedge clk);
    op = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(rdata == 8'h5A, "R10 ignored start result", rdata, 8'h5A);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 single done", {done, busy}, 0);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R10 no second command", busy, 0);

    // R10: start in the done cycle is accepted
    push_byte(8'hC3);
    kick(2'd3, 8'hC3);
    wait_done(cyc);
    chk(rdata == 8'hC3, "R10 back-to-back first", rdata, 8'hC3);
    exp_q.push_back(3 * CPU);
    kick(2'd2, 8'h00);
    chk(busy == 1'b1, "R10 accepted in done cycle", busy, 1);
    wait_done(cyc);
    chk(rdata == 8'h01, "R10 back-to-back second", rdata, 1);
    repeat (10) @(negedge clk);

    // R7: bus held low refuses the command
    dev_hold = 1'b1;
    repeat (20) @(negedge clk);
    kick(2'd0, 8'h00);
    wait_done(cyc);
    chk(err_idle == 1'b1, "R7 err_idle", err_idle, 1);
    chk(cyc == 1, "R7 refusal latency", cyc, 1);
    chk(busy == 1'b0, "R7 stays idle", busy, 0);
    dev_hold = 1'b0;
    repeat (20) @(negedge clk);

    // R8: an 8-clock low glitch at start is ignored
    dev_hold = 1'b1;
    repeat (4) @(negedge clk);
    exp_q.push_back(600 * CPU);
    kick(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    dev_hold = 1'b0;
    wait_done(cyc);
    chk(err_idle == 1'b0, "R8 glitch ignored", err_idle, 0);
    chk(presence == 1'b0, "R8 glitch no presence", presence, 0);
    repeat (20) @(negedge clk);

    // R9: bus stuck low after a slot aborts on timeout
    mode = 3;
    exp_q.push_back(3 * CPU);
    kick(2'd2, 8'h00);
    wait_done(cyc);
    chk(err_timeout == 1'b1, "R9 err_timeout", err_timeout, 1);
    chk(cyc >= 39990 && cyc <= 40010, "R9 timeout latency", cyc, 40001);
    chk(drv == 1'b0, "R9 bus released", drv, 0);
    mode = 0;
    dev_stuck = 1'b0;
    repeat (50) @(negedge clk);
    do_slot(2'd1, 1'b1, 1'b1, "R9 engine usable after timeout");
    chk(err_timeout == 1'b0, "R9 flag cleared", err_timeout, 0);
    chk(exp_q.size() == 0, "R10 all pulses seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule